// File: doc/BRIEF.md
# Windowed Register-Write Watchdog

This block supervises a host that must keep writing registers. A prescaler turns the system clock into a slow tick: one tick every `PRESCALE` clocks, which is 1024 by default, so 1.2288 MHz gives 1200 Hz. A counter counts the ticks since the last servicing write. If the count passes a programmable upper limit, the block raises an error.

An optional lower limit turns the watchdog into a window. While the lower limit is active, only a write to the watchdog's own address services it. Such a write is itself an error if it comes too early or after the timer has already expired. With the lower limit off, a write to any address services it.

Errors set a sticky fault output. A status read clears the fault, except while the expired condition is still present.

Top module: `wr_window_wdt`

## Requirements
- R1: After reset, `fault` is low and the tick count is zero.
- R2: While `cfg_en` is low, no error is raised and writes have no effect, whatever the address or the limit codes.
- R3: When a servicing write or the enabling edge is followed by no servicing write, `fault` rises on clock edge (N+1)*PRESCALE after that event and not earlier. N is the upper code mapped as 0→64, 1→128, 2→512, 3→1024, 4→2048, 5→3072, 6→4096, 7→6144 ticks.
- R4: With lower code 0, a write to any address restarts the count at zero and raises no error.
- R5: With a nonzero lower code, only a write whose address equals `OWN_ADDR` (default 0x11) restarts the count. Writes to other addresses leave the running count and the expiry time unchanged.
- R6: With a nonzero lower code L, mapped as 1→64, 2→128, 3→512 ticks, an own-address write made when fewer than L whole ticks have elapsed sets `fault`. One made after L or more ticks does not.
- R7: A status read clears `fault` on the next edge, unless the timer is expired and not yet serviced. In that case the fault stays set.
- R8: If an error and a status read fall in the same cycle, `fault` is set after that edge.
- R9: In window mode, an own-address write after expiry sets `fault`. Every servicing write, including one that raised an error, restarts the count from zero.
- R10: Raising `cfg_en` starts the count at zero. Lowering it clears the count and the expired condition but leaves `fault` set until it is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host register-write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Address of the register being written |
| cfg_en | input | 1 | Watchdog enable |
| cfg_upper | input | 3 | Upper-limit code |
| cfg_lower | input | 2 | Lower-limit code, 0 turns the window off |
| stat_rd | input | 1 | Status-read strobe that clears the sticky fault |
| fault | output | 1 | Sticky watchdog fault |

## Verification
The two functions that collide are the read-clear of the sticky fault and a new error, in two forms.

The first form is an early own-address write driven in the same cycle as a status read while the fault is already set. The second is a status read held high through the exact edge on which the upper limit expires.

In both cases the fault must still read high afterwards. A lone read must then clear it, once the expired condition has been removed by a servicing write. A behavioural model that counts elapsed clocks judges every edge.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    // Largest upper limit in ticks; the tick counter is sized from it.
    localparam int unsigned MAX_UPPER_TICKS = 6144;
    localparam int unsigned TICK_W          = $clog2(MAX_UPPER_TICKS + 1);

    typedef logic [TICK_W-1:0] tick_cnt_t;

    typedef struct packed {
        tick_cnt_t cnt;      // whole ticks since last servicing write
        logic      overdue;  // upper limit passed, not yet serviced
    } wdw_timer_t;

    typedef struct packed {
        logic fault;
    } wdw_fault_t;

    // Upper-limit code to tick count (non-uniform spacing).
    function automatic tick_cnt_t upper_ticks(input logic [2:0] code);
        tick_cnt_t v;
        case (code)
            3'd0:    v = tick_cnt_t'(64);
            3'd1:    v = tick_cnt_t'(128);
            3'd2:    v = tick_cnt_t'(512);
            3'd3:    v = tick_cnt_t'(1024);
            3'd4:    v = tick_cnt_t'(2048);
            3'd5:    v = tick_cnt_t'(3072);
            3'd6:    v = tick_cnt_t'(4096);
            default: v = tick_cnt_t'(6144);
        endcase
        return v;
    endfunction

    // Lower-limit code to tick count; code 0 means no window.
    function automatic tick_cnt_t lower_ticks(input logic [1:0] code);
        tick_cnt_t v;
        case (code)
            2'd0:    v = '0;
            2'd1:    v = tick_cnt_t'(64);
            2'd2:    v = tick_cnt_t'(128);
            default: v = tick_cnt_t'(512);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/wdw_tick_gen.sv
module wdw_tick_gen #(
    parameter int unsigned PRESCALE = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);

    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_div
            localparam int unsigned PRE_W = $clog2(PRESCALE);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

            typedef struct packed {
                logic [PRE_W-1:0] pre;
            } pre_state_t;

            pre_state_t s_d, s_q;

            assign tick = run && (s_q.pre == PRE_LAST);

            always_comb begin
                s_d = s_q;
                if (!run || restart || tick) begin
                    s_d.pre = '0;
                end else begin
                    s_d.pre = s_q.pre + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s_q <= '0;
                end else begin
                    s_q <= s_d;
                end
            end

            // R3
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/wdw_limit_lut.sv
module wdw_limit_lut
    import wdw_pkg::*;
(
    input  logic [2:0] upper_code,
    input  logic [1:0] lower_code,
    output tick_cnt_t  upper_lim,
    output tick_cnt_t  lower_lim,
    output logic       window_en
);

    always_comb begin
        upper_lim = upper_ticks(upper_code);
        lower_lim = lower_ticks(lower_code);
        window_en = (lower_code != 2'd0);
    end

endmodule

// File: rtl/wdw_window_timer.sv
module wdw_window_timer
    import wdw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      tick,
    input  logic      qual_wr,
    input  logic      window_en,
    input  tick_cnt_t upper_lim,
    input  tick_cnt_t lower_lim,
    output logic      err,
    output logic      overdue
);

    wdw_timer_t s_d, s_q;

    assign overdue = s_q.overdue;

    always_comb begin
        s_d = s_q;
        err = 1'b0;
        if (!en) begin
            s_d = '0;
        end else if (qual_wr) begin
            // early or late servicing in window mode is an error
            err         = window_en && ((s_q.cnt < lower_lim) || s_q.overdue);
            s_d.cnt     = '0;
            s_d.overdue = 1'b0;
        end else if (tick && !s_q.overdue) begin
            if (s_q.cnt >= upper_lim) begin
                s_d.overdue = 1'b1;
                err         = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (s_q.cnt == '0) && !s_q.overdue);

    // R9
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && qual_wr) |=> (s_q.cnt == '0) && !s_q.overdue);

    // R3
    expire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.overdue) |-> $past(tick));

endmodule

// File: rtl/wdw_fault_latch.sv
module wdw_fault_latch
    import wdw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err,
    input  logic stat_rd,
    input  logic hold,
    output logic fault
);

    wdw_fault_t s_d, s_q;

    assign fault = s_q.fault;

    always_comb begin
        s_d = s_q;
        if (err) begin
            s_d.fault = 1'b1;
        end else if (stat_rd && !hold) begin
            s_d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8
    err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> fault);

    // R7
    clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> ($past(stat_rd) && !$past(hold)));

endmodule

// File: rtl/wr_window_wdt.sv
module wr_window_wdt
    import wdw_pkg::*;
#(
    parameter int unsigned PRESCALE = 1024,
    parameter int unsigned ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] OWN_ADDR = ADDR_W'(17)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              cfg_en,
    input  logic [2:0]        cfg_upper,
    input  logic [1:0]        cfg_lower,
    input  logic              stat_rd,
    output logic              fault
);

    tick_cnt_t upper_lim;
    tick_cnt_t lower_lim;
    logic      window_en;
    logic      qual_wr;
    logic      tick;
    logic      err;
    logic      overdue;

    wdw_limit_lut u_lut (
        .upper_code (cfg_upper),
        .lower_code (cfg_lower),
        .upper_lim  (upper_lim),
        .lower_lim  (lower_lim),
        .window_en  (window_en)
    );

    // In window mode only the watchdog's own address services it.
    assign qual_wr = cfg_en && wr_valid && (!window_en || (wr_addr == OWN_ADDR));

    wdw_tick_gen #(
        .PRESCALE (PRESCALE)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cfg_en),
        .restart (qual_wr),
        .tick    (tick)
    );

    wdw_window_timer u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .tick      (tick),
        .qual_wr   (qual_wr),
        .window_en (window_en),
        .upper_lim (upper_lim),
        .lower_lim (lower_lim),
        .err       (err),
        .overdue   (overdue)
    );

    wdw_fault_latch u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .err     (err),
        .stat_rd (stat_rd),
        .hold    (overdue),
        .fault   (fault)
    );

    // R2
    no_fault_rise_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !fault) |=> !fault);

endmodule

// File: tb/wr_window_wdt_tb.sv
module wr_window_wdt_tb;

    localparam int DIV = 4;
    localparam logic [5:0] OWN = 6'h11;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_valid;
    logic [5:0] wr_addr;
    logic       cfg_en;
    logic [2:0] cfg_upper;
    logic [1:0] cfg_lower;
    logic       stat_rd;
    logic       fault;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    wr_window_wdt #(
        .PRESCALE (DIV),
        .ADDR_W   (6),
        .OWN_ADDR (OWN)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .cfg_en    (cfg_en),
        .cfg_upper (cfg_upper),
        .cfg_lower (cfg_lower),
        .stat_rd   (stat_rd),
        .fault     (fault)
    );

    // Behavioural reference: elapsed clocks since the last restart.
    int elapsed = 0;
    bit m_over  = 0;
    bit m_fault = 0;

    function automatic int up_of(input logic [2:0] c);
        int t[8] = '{64, 128, 512, 1024, 2048, 3072, 4096, 6144};
        return t[c];
    endfunction

    function automatic int lo_of(input logic [1:0] c);
        int t[4] = '{0, 64, 128, 512};
        return t[c];
    endfunction

    always @(posedge clk) begin
        bit err;
        bit was_over;
        bit win;
        bit serve;
        if (!rst_n) begin
            elapsed = 0; m_over = 0; m_fault = 0;
        end else begin
            err      = 0;
            was_over = m_over;
            win      = (cfg_lower != 0);
            serve    = wr_valid && (!win || wr_addr == OWN);
            if (!cfg_en) begin
                elapsed = 0; m_over = 0;
            end else if (serve) begin
                err     = win && ((elapsed / DIV) < lo_of(cfg_lower) || m_over);
                elapsed = 0; m_over = 0;
            end else if (!m_over) begin
                if (((elapsed + 1) % DIV == 0) && (elapsed / DIV) >= up_of(cfg_upper)) begin
                    m_over = 1; err = 1;
                end else begin
                    elapsed++;
                end
            end
            if (err) m_fault = 1;
            else if (stat_rd && !was_over) m_fault = 0;
        end
    end

    // Compare with the model on every falling edge (R3..R10 via model).
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (fault !== m_fault) begin
                bad++;
                $display("FAIL model R3-model compare t=%0t actual=%0b expected=%0b",
                         $time, fault, m_fault);
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [5:0] a);
        wr_valid = 1'b1; wr_addr = a;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_read();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic write_and_read(input logic [5:0] a);
        wr_valid = 1'b1; wr_addr = a; stat_rd = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; stat_rd = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int e;
        int lt;
        rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; cfg_en = 1'b0;
        cfg_upper = 3'd0; cfg_lower = 2'd0; stat_rd = 1'b0;
        idle(5);
        rst_n = 1'b1;
        idle(1);
        chk(fault, 1'b0, "R1 reset");

        // R2: disabled, writes and long waits do nothing
        for (int i = 0; i < 5; i++) begin
            cfg_lower = 2'(i);
            do_write(6'(i * 9));
            do_write(OWN);
            idle(150);
        end
        cfg_lower = 2'd0;
        chk(fault, 1'b0, "R2 disabled");

        // R10 + R3: enable edge starts at zero, code 0 expiry
        e = 65 * DIV;
        cfg_en = 1'b1; cfg_upper = 3'd0;
        idle(e - 1);
        chk(fault, 1'b0, "R10 enable start");
        idle(1);
        chk(fault, 1'b1, "R3 expiry code0");

        // R7: read while overdue keeps fault, after service it clears
        do_read();
        chk(fault, 1'b1, "R7 overdue hold");
        do_write(6'h02);
        chk(fault, 1'b1, "R4 service no clear");
        do_read();
        chk(fault, 1'b0, "R7 read clear");

        // R4: writes to varied addresses keep it alive
        for (int i = 0; i < 6; i++) begin
            idle(199);
            do_write(6'(i * 7 + 1));
        end
        chk(fault, 1'b0, "R4 any addr restarts");

        // R3: every upper code
        for (int c = 0; c < 8; c++) begin
            cfg_upper = 3'(c);
            e = (up_of(3'(c)) + 1) * DIV;
            do_write(6'h05);
            do_read();
            chk(fault, 1'b0, "R3 cleared before run");
            idle(e - 2);
            chk(fault, 1'b0, "R3 before expiry");
            idle(1);
            chk(fault, 1'b1, "R3 at expiry");
        end

        // R9: late own write in window mode
        cfg_upper = 3'd2; cfg_lower = 2'd1;
        do_write(OWN);
        chk(fault, 1'b1, "R9 late write");
        do_read();
        chk(fault, 1'b0, "R7 clear after late");

        // R5: foreign writes do not restart
        e = 513 * DIV;
        idle(500);
        do_write(6'h05);
        idle(800);
        do_write(6'h12);
        chk(fault, 1'b0, "R5 foreign write no error");
        idle(e - 1303 - 1);
        chk(fault, 1'b0, "R5 before expiry");
        idle(1);
        chk(fault, 1'b1, "R5 foreign writes ignored");

        // R8: early error and read in the same cycle
        do_write(OWN);
        do_read();
        chk(fault, 1'b0, "R7 clear");
        idle(10);
        do_write(OWN);
        chk(fault, 1'b1, "R6 early");
        idle(3);
        write_and_read(OWN);
        chk(fault, 1'b1, "R8 error with read");
        stat_rd = 1'b1;
        idle(e - 1);
        chk(fault, 1'b0, "R8 held read before expiry");
        idle(1);
        chk(fault, 1'b1, "R8 read at expiry");
        stat_rd = 1'b0;

        // R6: lower-code boundaries
        cfg_upper = 3'd7;
        for (int c = 1; c < 4; c++) begin
            lt = lo_of(2'(c));
            cfg_lower = 2'd0;
            do_write(6'h07);
            do_read();
            chk(fault, 1'b0, "R6 setup clear");
            cfg_lower = 2'(c);
            idle(lt * DIV - 1);
            do_write(OWN);
            chk(fault, 1'b0, "R6 on-time write");
            idle(lt * DIV - 1);
            do_write(OWN);
            chk(fault, 1'b1, "R6 one tick early");
        end

        // R10: disable keeps fault, re-enable restarts count
        cfg_en = 1'b0;
        idle(5);
        chk(fault, 1'b1, "R10 disable keeps fault");
        do_read();
        chk(fault, 1'b0, "R10 read while disabled");
        cfg_lower = 2'd0; cfg_upper = 3'd0;
        e = 65 * DIV;
        cfg_en = 1'b1;
        idle(150);
        cfg_en = 1'b0;
        idle(3);
        cfg_en = 1'b1;
        idle(e - 1);
        chk(fault, 1'b0, "R10 restart from zero");
        idle(1);
        chk(fault, 1'b1, "R10 expiry after re-enable");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule